// File: doc/BRIEF.md
# Timer Output Compare Unit

This block sits beside an 8-bit timer counter. It compares the live count against an active compare value and raises a sticky match flag that an interrupt controller can sample. It also drives one waveform output bit. A two-bit output action field decides whether that bit is left alone, toggled, cleared or set. The counter, the prescaler, interrupt routing and pin direction logic all sit outside this block.

A two-bit mode selects how the unit behaves. In the two non-PWM modes, software writes the compare value straight into the active register, and a force strobe can move the output pin. In the two PWM modes, software writes land in a shadow buffer. The buffer is copied into the active register only at a counting extreme, so a pulse width never changes in the middle of a period. A software write to the counter blocks the match on the next timer tick, so the compare value can be preloaded equal to the count without a spurious event.

Top module: `timer_compare_unit`

## Requirements
- R1: On a cycle with `tickEn` high, `cntVal` equal to the active compare value, and no block from R6, `matchFlag` is 1 from the next cycle and stays set. `flagClr` clears it, but a match in the same cycle takes priority and the flag stays 1.
- R2: The mode encoding on `modeSel` is 00 = normal, 01 = clear-on-compare, 10 = fast PWM, 11 = phase-correct PWM. In modes 00 and 01, a `cmpWrEn` write becomes the active compare value in the next cycle.
- R3: In modes 10 and 11, `cmpWrEn` writes only the buffer. The buffer is copied to the active value on a tick with `atBottom` high in mode 10, or on a tick with `atTop` high in mode 11. At all other times the active value holds.
- R4: In modes 00 and 01, a match changes `waveOut` according to `outMode`: 00 = no change, 01 = toggle, 10 = clear, 11 = set.
- R5: In modes 00 and 01, `forceStb` applies the R4 action to `waveOut` and leaves `matchFlag` untouched. In modes 10 and 11, `forceStb` has no effect.
- R6: A `cntWrEn` pulse blocks the match on the first tick in or after the write cycle, however many idle cycles pass before that tick. Later ticks match normally.
- R7: In mode 10, `outMode` 10 clears `waveOut` on a match and sets it on a BOTTOM tick. `outMode` 11 does the reverse. When both occur together, the match action wins. `outMode` 0x leaves `waveOut` unchanged.
- R8: In mode 11, `outMode` 10 clears `waveOut` on a match while counting up (`cntDown` = 0) and sets it on a match while counting down. `outMode` 11 does the reverse.
- R9: After reset, `matchFlag`, `waveOut`, the buffer and the active value are 0. Changing `modeSel` does not change `waveOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer clock enable, one cycle per count step |
| cntVal | input | 8 | Current counter value |
| cntDown | input | 1 | 1 while the counter counts down |
| atTop | input | 1 | Counter is at TOP on this tick |
| atBottom | input | 1 | Counter is at BOTTOM on this tick |
| modeSel | input | 2 | Waveform mode (encoding in R2) |
| outMode | input | 2 | Output action field |
| cmpWrEn | input | 1 | Software write strobe for the compare value |
| cmpWrData | input | 8 | Data for the compare write |
| cntWrEn | input | 1 | Software wrote the counter this cycle |
| forceStb | input | 1 | Force-compare strobe |
| flagClr | input | 1 | Software clear of the match flag |
| matchFlag | output | 1 | Sticky compare match flag |
| waveOut | output | 1 | Waveform output bit |

## Verification
Stimulus steps through all four waveform modes. The match logic is driven with equal and unequal counts, which separates real matches from false ones. Ticks are issued with and without a preceding counter write, so a block that is consumed can be told apart from one that lingers. In the PWM modes, the counter is placed on the new compare value before the update point, then the update point is hit, then the new value is reached again. This shows whether writes wait for TOP or BOTTOM. Up and down matches in phase-correct mode, and force strobes in every mode, show whether each action follows direction and mode.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_CLRCMP = 2'b01,
    MODE_FAST   = 2'b10,
    MODE_PHASE  = 2'b11
  } waveMode_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TGL  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } outAct_e;

  typedef struct packed {
    logic wrActive;
    logic wrBuffer;
    logic pullBuffer;
    logic setFlag;
    logic clrFlag;
    logic setWave;
    logic clrWave;
    logic tglWave;
  } ocStrobe_t;

endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cntDown,
  input  logic       atTop,
  input  logic       atBottom,
  input  logic [1:0] modeSel,
  input  logic [1:0] outMode,
  input  logic       cmpWrEn,
  input  logic       cntWrEn,
  input  logic       forceStb,
  input  logic       flagClr,
  input  logic       cmpEq,
  output ocStrobe_t  strobes
);

  waveMode_e mode;
  outAct_e   act;
  logic      isPwm;
  logic      blockFlag;
  logic      blockNow;
  logic      hit;
  logic      forceHit;
  logic      pwmEdge;

  assign mode     = waveMode_e'(modeSel);
  assign act      = outAct_e'(outMode);
  assign isPwm    = modeSel[1];
  assign blockNow = blockFlag | cntWrEn;
  assign hit      = tickEn & cmpEq & ~blockNow;
  assign forceHit = forceStb & ~isPwm;
  assign pwmEdge  = (mode == MODE_FAST) ? atBottom : atTop;

  // The block is consumed by the first tick; a tick in the write cycle itself counts.
  always_ff @(posedge clk) begin
    if (!rstN)        blockFlag <= 1'b0;
    else if (cntWrEn) blockFlag <= ~tickEn;
    else if (tickEn)  blockFlag <= 1'b0;
  end

  always_comb begin
    strobes            = '0;
    strobes.wrBuffer   = cmpWrEn;
    strobes.wrActive   = cmpWrEn & ~isPwm;
    strobes.pullBuffer = isPwm & tickEn & pwmEdge;
    strobes.setFlag    = hit;
    strobes.clrFlag    = flagClr;
    unique case (mode)
      MODE_NORMAL, MODE_CLRCMP: begin
        if (hit | forceHit) begin
          strobes.tglWave = (act == ACT_TGL);
          strobes.clrWave = (act == ACT_CLR);
          strobes.setWave = (act == ACT_SET);
        end
      end
      MODE_FAST: begin
        if (hit) begin
          strobes.clrWave = (act == ACT_CLR);
          strobes.setWave = (act == ACT_SET);
        end else if (tickEn & atBottom) begin
          strobes.setWave = (act == ACT_CLR);
          strobes.clrWave = (act == ACT_SET);
        end
      end
      MODE_PHASE: begin
        if (hit) begin
          strobes.clrWave = ((act == ACT_CLR) & ~cntDown) | ((act == ACT_SET) & cntDown);
          strobes.setWave = ((act == ACT_SET) & ~cntDown) | ((act == ACT_CLR) & cntDown);
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/oc_datapath.sv
module oc_datapath
  import oc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ocStrobe_t    strobes,
  input  logic [W-1:0] cmpWrData,
  input  logic [W-1:0] cntVal,
  output logic         cmpEq,
  output logic [W-1:0] activeCmp,
  output logic         matchFlag,
  output logic         waveOut
);

  logic [W-1:0] bufCmp;

  always_ff @(posedge clk) begin
    if (!rstN)                 bufCmp <= '0;
    else if (strobes.wrBuffer) bufCmp <= cmpWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   activeCmp <= '0;
    else if (strobes.wrActive)   activeCmp <= cmpWrData;
    else if (strobes.pullBuffer) activeCmp <= bufCmp;
  end

  assign cmpEq = (cntVal == activeCmp);

  always_ff @(posedge clk) begin
    if (!rstN)                matchFlag <= 1'b0;
    else if (strobes.setFlag) matchFlag <= 1'b1;
    else if (strobes.clrFlag) matchFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                waveOut <= 1'b0;
    else if (strobes.setWave) waveOut <= 1'b1;
    else if (strobes.clrWave) waveOut <= 1'b0;
    else if (strobes.tglWave) waveOut <= ~waveOut;
  end

endmodule

// File: rtl/timer_compare_unit.sv
module timer_compare_unit
  import oc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic [W-1:0] cntVal,
  input  logic         cntDown,
  input  logic         atTop,
  input  logic         atBottom,
  input  logic [1:0]   modeSel,
  input  logic [1:0]   outMode,
  input  logic         cmpWrEn,
  input  logic [W-1:0] cmpWrData,
  input  logic         cntWrEn,
  input  logic         forceStb,
  input  logic         flagClr,
  output logic         matchFlag,
  output logic         waveOut
);

  ocStrobe_t    strobes;
  logic         cmpEq;
  logic [W-1:0] activeCmp;

  oc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntDown(cntDown),
    .atTop(atTop), .atBottom(atBottom), .modeSel(modeSel), .outMode(outMode),
    .cmpWrEn(cmpWrEn), .cntWrEn(cntWrEn), .forceStb(forceStb),
    .flagClr(flagClr), .cmpEq(cmpEq), .strobes(strobes)
  );

  oc_datapath #(.W(W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmpWrData(cmpWrData),
    .cntVal(cntVal), .cmpEq(cmpEq), .activeCmp(activeCmp),
    .matchFlag(matchFlag), .waveOut(waveOut)
  );

endmodule

// File: rtl/oc_check.sv
module oc_check #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         tickEn,
  input logic [1:0]   modeSel,
  input logic [1:0]   outMode,
  input logic         cmpWrEn,
  input logic [W-1:0] cmpWrData,
  input logic         cntWrEn,
  input logic         forceStb,
  input logic         flagClr,
  input logic         matchFlag,
  input logic         waveOut,
  input logic [W-1:0] activeCmp
);

  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(tickEn)); // R1
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !tickEn) |=> !matchFlag); // R1
  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmpWrEn && !modeSel[1]) |=> (activeCmp == $past(cmpWrData))); // R2
  AST_PWM_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel[1] && !tickEn) |=> $stable(activeCmp)); // R3
  AST_DISCONNECTED: assert property (@(posedge clk) disable iff (!rstN)
    (outMode == 2'b00) |=> $stable(waveOut)); // R4
  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (forceStb && !tickEn && !matchFlag) |=> !matchFlag); // R5
  AST_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrEn && !matchFlag) |=> !matchFlag); // R6

endmodule

bind timer_compare_unit oc_check #(.W(W)) i_oc_check (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .modeSel(modeSel), .outMode(outMode),
  .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .cntWrEn(cntWrEn),
  .forceStb(forceStb), .flagClr(flagClr), .matchFlag(matchFlag),
  .waveOut(waveOut), .activeCmp(activeCmp)
);

// File: tb/test_timer_compare_unit.sv
module test_timer_compare_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] cntVal = '0;
  logic       cntDown = 1'b0;
  logic       atTop = 1'b0;
  logic       atBottom = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [1:0] outMode = 2'b00;
  logic       cmpWrEn = 1'b0;
  logic [7:0] cmpWrData = '0;
  logic       cntWrEn = 1'b0;
  logic       forceStb = 1'b0;
  logic       flagClr = 1'b0;
  logic       matchFlag;
  logic       waveOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [1:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  timer_compare_unit i_timer_compare_unit (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntVal(cntVal), .cntDown(cntDown),
    .atTop(atTop), .atBottom(atBottom), .modeSel(modeSel), .outMode(outMode),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .cntWrEn(cntWrEn),
    .forceStb(forceStb), .flagClr(flagClr), .matchFlag(matchFlag), .waveOut(waveOut)
  );

  // Driver: inputs staged after a falling edge, clocked in, expectation queued.
  task automatic go(input string tag, input bit eFlag, input bit eWave);
    @(posedge clk);
    expQ.push_back({eFlag, eWave});
    tagQ.push_back(tag);
    @(negedge clk);
    tickEn = 1'b0; atTop = 1'b0; atBottom = 1'b0;
    cmpWrEn = 1'b0; cntWrEn = 1'b0; forceStb = 1'b0; flagClr = 1'b0;
  endtask

  // Monitor: compare results away from the active edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      total++;
      if ({matchFlag, waveOut} !== e) begin
        bad++;
        $display("FAIL %s flag=%0b/%0b wave=%0b/%0b (actual/expected)",
                 t, matchFlag, e[1], waveOut, e[0]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    go("R9 reset state", 0, 0);
    // normal mode
    outMode = 2'b01; cmpWrEn = 1; cmpWrData = 8'd5; go("R2 write", 0, 0);
    tickEn = 1; cntVal = 8'd5; go("R1 R4 toggle on match", 1, 1);
    tickEn = 1; flagClr = 1; go("R1 set beats clear", 1, 0);
    flagClr = 1; go("R1 clear", 0, 0);
    outMode = 2'b11; tickEn = 1; go("R4 set", 1, 1);
    flagClr = 1; go("R1 clear", 0, 1);
    outMode = 2'b10; tickEn = 1; cntVal = 8'd4; go("R1 no match", 0, 1);
    tickEn = 1; cntVal = 8'd5; go("R4 clear", 1, 0);
    flagClr = 1; go("R1 clear", 0, 0);
    outMode = 2'b11; forceStb = 1; go("R5 force set no flag", 0, 1);
    outMode = 2'b01; forceStb = 1; go("R5 force toggle", 0, 0);
    outMode = 2'b00; tickEn = 1; go("R4 disconnected", 1, 0);
    flagClr = 1; go("R1 clear", 0, 0);
    // clear-on-compare mode
    modeSel = 2'b01; cmpWrEn = 1; cmpWrData = 8'd9; go("R2 write", 0, 0);
    outMode = 2'b01; tickEn = 1; cntVal = 8'd9; go("R2 new value matches", 1, 1);
    flagClr = 1; cntWrEn = 1; go("R6 counter write", 0, 1);
    go("R6 idle", 0, 1);
    go("R6 idle", 0, 1);
    tickEn = 1; go("R6 blocked tick", 0, 1);
    tickEn = 1; go("R6 next tick matches", 1, 0);
    flagClr = 1; go("R1 clear", 0, 0);
    tickEn = 1; cntWrEn = 1; go("R6 same cycle blocked", 0, 0);
    tickEn = 1; go("R6 follow-up matches", 1, 1);
    // fast PWM
    flagClr = 1; modeSel = 2'b10; outMode = 2'b10; go("R9 mode change holds", 0, 1);
    cmpWrEn = 1; cmpWrData = 8'd20; go("R3 buffered write", 0, 1);
    tickEn = 1; cntVal = 8'd20; go("R3 not yet active", 0, 1);
    tickEn = 1; cntVal = 8'd9; go("R7 clear on match", 1, 0);
    flagClr = 1; tickEn = 1; atBottom = 1; cntVal = 8'd0; go("R7 set at bottom", 0, 1);
    tickEn = 1; cntVal = 8'd20; go("R3 R7 new value", 1, 0);
    flagClr = 1; outMode = 2'b11; forceStb = 1; go("R5 ignored in PWM", 0, 0);
    tickEn = 1; atBottom = 1; cntVal = 8'd0; go("R7 inverse bottom", 0, 0);
    tickEn = 1; cntVal = 8'd20; go("R7 inverse match", 1, 1);
    // phase-correct PWM
    flagClr = 1; modeSel = 2'b11; cmpWrEn = 1; cmpWrData = 8'd30; go("R9 mode change holds", 0, 1);
    outMode = 2'b10; tickEn = 1; cntDown = 0; cntVal = 8'd20; go("R8 up clear", 1, 0);
    flagClr = 1; tickEn = 1; atBottom = 1; cntVal = 8'd0; go("R3 no bottom update", 0, 0);
    tickEn = 1; cntVal = 8'd30; go("R3 still old value", 0, 0);
    tickEn = 1; cntDown = 1; cntVal = 8'd20; go("R8 down set", 1, 1);
    flagClr = 1; tickEn = 1; atTop = 1; cntVal = 8'd255; go("R3 top update", 0, 1);
    tickEn = 1; cntDown = 0; cntVal = 8'd30; go("R3 R8 up clear new", 1, 0);
    outMode = 2'b11; tickEn = 1; go("R8 inverse up set", 1, 1);
    tickEn = 1; cntDown = 1; go("R8 inverse down clear", 1, 0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule